// File: doc/BRIEF.md
# Oversampled I2C Target with Nine-Register Control Bank

This block is a bus target for a two-wire serial control bus. It runs entirely on a fast system clock that oversamples the bus lines. Both lines pass through a synchronizer and a glitch filter before the START, STOP and clock edges are detected. The block answers one 7-bit chip address. The top six bits of that address are fixed and the lowest bit comes from a strap pin.

A write transfer has three parts: the chip address, one subaddress byte, and any number of data bytes. The subaddress names one of nine 8-bit control registers and carries a per-transfer auto-increment flag. With the flag clear, every data byte lands in the same register. With the flag set, the data bytes fill consecutive registers.

A read transfer does not return register contents. It returns a live status byte built from two mute flags. The status byte is taken again for every byte, so the master can keep clocking out fresh copies without sending the address again.

The register contents appear on a flat output bus. The block drives SDA only through an open-drain pull-down enable.

Top module: `i2c_regbank_target`

## Requirements
- R1: The target acknowledges (pulls SDA low during the ninth clock) a chip address byte whose bits 7..1 equal 1,0,0,0,1,0,`addr_sel`. Bit 0 selects read (1) or write (0).
- R2: After a chip address that does not match, `sda_oe` stays low until the next START or STOP.
- R3: In the subaddress byte, bits 3:0 pick the register and bit 4 enables auto-increment; bits 7:5 have no effect. An index of 9 or more is not acknowledged, and data bytes that follow it are neither acknowledged nor stored.
- R4: With auto-increment clear, every data byte of the transfer is written to the same register and is acknowledged.
- R5: With auto-increment set, successive data bytes go to successive registers. Bytes aimed past register 8 are not acknowledged and are dropped.
- R6: All nine registers hold 0xFE after reset. A register changes only through an acknowledged write. Register i appears on `regs_o[8i+7:8i]`.
- R7: In a read, the target sends a byte MSB first with bit 2 = `soft_mute`, bit 1 = `zc_mute`, and all other bits 1. The byte is sampled again at the start of each byte. After a master ACK another byte follows. After a master NACK, SDA stays released.
- R8: A repeated START (a START with no STOP before it) restarts chip address decoding, whatever state the transfer was in.
- R9: `sda_oe` changes only while the filtered SCL is low, so the target never creates a START or STOP.
- R10: Pulses on SCL or SDA shorter than `FILT_LEN` system clocks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| addr_sel | input | 1 | Strap for the lowest chip address bit |
| soft_mute | input | 1 | Status flag returned in read bit 2 |
| zc_mute | input | 1 | Status flag returned in read bit 1 |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| regs_o | output | 72 | Nine control registers, register i at bits 8i+7:8i |

## Verification
The assertions check four properties on every cycle:
- the SDA drive holds still while SCL is high;
- the SDA drive stays off after an address mismatch;
- no write ever reaches an index outside the bank;
- a register never moves without a write strobe for it.

Some behaviour only the bench scenarios can show: which register a byte lands in under each subaddress and auto-increment setting, where an auto-increment run stops being acknowledged, what the status bytes contain, how a repeated START is handled, and that short glitches are rejected. The bench shows these by comparing the register outputs against its own model on every quiet clock.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_SUB, PH_WDATA, PH_RDATA, PH_IGNORE
  } phase_t;

  localparam logic [5:0] CHIP_ID_HI = 6'b100010;
  localparam int STAT_SOFT_BIT = 2;
  localparam int STAT_ZC_BIT   = 1;
endpackage

// File: rtl/i2c_rb_filter.sv
module i2c_rb_filter #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter int FILT   = 3,
  localparam int CW    = $clog2(FILT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] filt_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] sync_q;
    logic [CW-1:0]     run_q;
    logic              lvl_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= '1;
        run_q  <= '0;
        lvl_q  <= 1'b1;
      end else begin
        sync_q <= {sync_q[STAGES-2:0], raw_i[g]};
        if (sync_q[STAGES-1] != lvl_q) begin
          if (run_q == CW'(FILT - 1)) begin
            lvl_q <= sync_q[STAGES-1];
            run_q <= '0;
          end else begin
            run_q <= run_q + 1'b1;
          end
        end else begin
          run_q <= '0;
        end
      end
    end

    assign filt_o[g] = lvl_q;
  end
endmodule

// File: rtl/i2c_rb_events.sv
module i2c_rb_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_q,
  output logic sda_q,
  output logic start_q,
  output logic stop_q,
  output logic rise_q,
  output logic fall_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      scl_q   <= scl_f;
      sda_q   <= sda_f;
      start_q <= scl_f & scl_q & sda_q & ~sda_f;
      stop_q  <= scl_f & scl_q & ~sda_q & sda_f;
      rise_q  <= scl_f & ~scl_q;
      fall_q  <= ~scl_f & scl_q;
    end
  end

  // bus conditions are mutually exclusive in any cycle (R8, R9)
  assert_events_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_q, stop_q, rise_q, fall_q}));
endmodule

// File: rtl/i2c_rb_fsm.sv
module i2c_rb_fsm
  import i2c_rb_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 9,
  parameter int IDXW = 4,
  localparam int CW  = $clog2(DW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            sda_i,
  input  logic            scl_lvl,
  input  logic            addr_sel,
  input  logic            soft_mute,
  input  logic            zc_mute,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [DW-1:0]   wr_data,
  output logic            sda_oe
);
  phase_t          phase;
  logic [CW-1:0]   cnt;
  logic            in_ack;
  logic [DW-1:0]   shreg;
  logic [DW-1:0]   tx;
  logic [IDXW-1:0] ptr;
  logic            autoinc;
  logic            hit_q, rw_q, sub_ok, mack_ok;
  logic [DW-1:0]   status_w;
  logic            addr_hit;
  logic            sub_valid;
  logic            ptr_valid;
  logic            busy;

  always_comb begin
    status_w                = '1;
    status_w[STAT_SOFT_BIT] = soft_mute;
    status_w[STAT_ZC_BIT]   = zc_mute;
  end

  assign addr_hit  = (shreg[DW-1:1] == {CHIP_ID_HI, addr_sel});
  assign sub_valid = (int'(shreg[IDXW-1:0]) < NREG);
  assign ptr_valid = (int'(ptr) < NREG);
  assign busy      = (phase != PH_IDLE) && (phase != PH_IGNORE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      in_ack  <= 1'b0;
      shreg   <= '0;
      tx      <= '1;
      ptr     <= '0;
      autoinc <= 1'b0;
      hit_q   <= 1'b0;
      rw_q    <= 1'b0;
      sub_ok  <= 1'b0;
      mack_ok <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_i) begin
        phase  <= PH_ADDR;
        cnt    <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_i) begin
        phase  <= PH_IDLE;
        cnt    <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (busy && rise_i) begin
        if (cnt < CW'(DW)) begin
          shreg <= {shreg[DW-2:0], sda_i};
          cnt   <= cnt + 1'b1;
        end else begin
          mack_ok <= ~sda_i;
        end
      end else if (busy && fall_i) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          cnt    <= '0;
          sda_oe <= 1'b0;
          unique case (phase)
            PH_ADDR: begin
              if (!hit_q)     phase <= PH_IGNORE;
              else if (rw_q) begin
                phase  <= PH_RDATA;
                tx     <= status_w;
                sda_oe <= ~status_w[DW-1];
              end else        phase <= PH_SUB;
            end
            PH_SUB:   phase <= sub_ok ? PH_WDATA : PH_IGNORE;
            PH_RDATA: begin
              if (mack_ok) begin
                tx     <= status_w;
                sda_oe <= ~status_w[DW-1];
              end else begin
                phase <= PH_IGNORE;
              end
            end
            default: ;
          endcase
        end else if (cnt == CW'(DW)) begin
          in_ack <= 1'b1;
          unique case (phase)
            PH_ADDR: begin
              hit_q  <= addr_hit;
              rw_q   <= shreg[0];
              sda_oe <= addr_hit;
            end
            PH_SUB: begin
              ptr     <= shreg[IDXW-1:0];
              autoinc <= shreg[IDXW];
              sub_ok  <= sub_valid;
              sda_oe  <= sub_valid;
            end
            PH_WDATA: begin
              if (ptr_valid) begin
                wr_en   <= 1'b1;
                wr_idx  <= ptr;
                wr_data <= shreg;
                sda_oe  <= 1'b1;
                if (autoinc) ptr <= ptr + 1'b1;
              end
            end
            default: sda_oe <= 1'b0;
          endcase
        end else if (phase == PH_RDATA && cnt != '0) begin
          sda_oe <= ~tx[DW - 1 - int'(cnt)];
        end
      end
    end
  end

  // drive on SDA never moves while SCL is high
  assert_oe_stable_scl_high_R9: assert property (@(posedge clk) disable iff (rst)
    (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

  // a rejected transfer never pulls SDA
  assert_ignore_released_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IGNORE) |-> !sda_oe);
endmodule

// File: rtl/i2c_rb_bank.sv
module i2c_rb_bank #(
  parameter int DW             = 8,
  parameter int NREG           = 9,
  parameter int IDXW           = 4,
  parameter logic [DW-1:0] RST = 8'hFE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDXW-1:0]    wr_idx,
  input  logic [DW-1:0]      wr_data,
  output logic [NREG*DW-1:0] regs_o
);
  logic [DW-1:0] mem_q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= RST;
    end else if (wr_en && int'(wr_idx) < NREG) begin
      mem_q[wr_idx] <= wr_data;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*DW +: DW] = mem_q[g];

    // a register only moves when a write strobe names it
    assert_reg_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !($past(wr_en) && int'($past(wr_idx)) == g) |-> $stable(mem_q[g]));
  end

  // the protocol engine never issues an out-of-bank write
  assert_idx_in_bank_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_idx) < NREG));
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
  parameter int DW             = 8,
  parameter int NREG           = 9,
  parameter int IDXW           = 4,
  parameter int SYNC_STAGES    = 2,
  parameter int FILT_LEN       = 3,
  parameter logic [DW-1:0] RST = 8'hFE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               addr_sel,
  input  logic               soft_mute,
  input  logic               zc_mute,
  output logic               sda_oe,
  output logic [NREG*DW-1:0] regs_o
);
  logic [1:0]      filt;
  logic            scl_q, sda_q, start_q, stop_q, rise_q, fall_q;
  logic            wr_en;
  logic [IDXW-1:0] wr_idx;
  logic [DW-1:0]   wr_data;

  i2c_rb_filter #(.WIDTH(2), .STAGES(SYNC_STAGES), .FILT(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .raw_i({scl_i, sda_i}), .filt_o(filt)
  );

  i2c_rb_events u_ev (
    .clk(clk), .rst(rst), .scl_f(filt[1]), .sda_f(filt[0]),
    .scl_q(scl_q), .sda_q(sda_q), .start_q(start_q), .stop_q(stop_q),
    .rise_q(rise_q), .fall_q(fall_q)
  );

  i2c_rb_fsm #(.DW(DW), .NREG(NREG), .IDXW(IDXW)) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_q), .stop_i(stop_q),
    .rise_i(rise_q), .fall_i(fall_q), .sda_i(sda_q), .scl_lvl(scl_q),
    .addr_sel(addr_sel), .soft_mute(soft_mute), .zc_mute(zc_mute),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  i2c_rb_bank #(.DW(DW), .NREG(NREG), .IDXW(IDXW), .RST(RST)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_o(regs_o)
  );
endmodule

// File: tb/sim_i2c_regbank_target.sv
`timescale 1ns/1ps
module sim_i2c_regbank_target;
  localparam int Q = 12;
  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_sel = 1'b0, soft_mute = 1'b0, zc_mute = 1'b0;
  logic sda_oe;
  logic [71:0] regs_o;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, failures = 0;
  logic [7:0] exp_reg [9];
  logic [7:0] dq [$];
  bit quiet = 1'b0;
  bit watch_rel = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_regbank_target u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel(addr_sel), .soft_mute(soft_mute), .zc_mute(zc_mute),
    .sda_oe(sda_oe), .regs_o(regs_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference model compared on every quiet clock (R6)
  always @(negedge clk) begin
    if (!rst && quiet && !done) begin
      for (int i = 0; i < 9; i++)
        check(regs_o[i*8 +: 8] == exp_reg[i], "R6", $sformatf("reg%0d", i),
              regs_o[i*8 +: 8], exp_reg[i]);
      check(!sda_oe, "R9", "idle sda_oe", sda_oe, 0);
    end
    if (!rst && watch_rel && !done)
      check(!sda_oe, "R2", "released after mismatch", sda_oe, 0);
  end

  task automatic bus_start();
    quiet = 1'b0;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(4*Q);
    watch_rel = 1'b0;
    quiet = 1'b1;
  endtask

  // glitch: 0 none, 1 short SCL pulse in a low phase, 2 short SDA dip in a high phase
  task automatic wbyte(input logic [7:0] b, input bit exp_ack, input string tag,
                       input int glitch);
    bit ack;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (glitch == 1 && i == 3) begin
        tick(Q/2); scl_m = 1'b1; tick(1); scl_m = 1'b0; tick(Q/2 - 1);
      end else tick(Q);
      scl_m = 1'b1;
      if (glitch == 2 && b[i]) begin
        tick(Q); sda_m = 1'b0; tick(1); sda_m = 1'b1; tick(Q - 1);
      end else tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = !sda_line;
    tick(Q);
    scl_m = 1'b0; tick(Q);
    check(ack == exp_ack, tag, $sformatf("ack for byte %0h", b), ack, exp_ack);
  endtask

  task automatic rbyte(output logic [7:0] b, input bit mack,
                       input logic s_next, input logic z_next);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = !mack; tick(Q);
    scl_m = 1'b1; tick(Q);
    soft_mute = s_next; zc_mute = z_next;
    tick(Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  // write transfer with an independent ack and register model
  task automatic txn(input logic [7:0] cbyte, input logic [7:0] sub, input int glitch,
                     input bit do_stop, input string tag);
    bit a_ok, s_ok;
    int ptr;
    bit inc;
    bus_start();
    a_ok = (cbyte[7:1] == {6'b100010, addr_sel}) && !cbyte[0];
    if (!a_ok) watch_rel = 1'b1;
    wbyte(cbyte, a_ok, tag, 0);
    s_ok = a_ok && (sub[3:0] < 9);
    ptr = int'(sub[3:0]);
    inc = sub[4];
    wbyte(sub, s_ok, tag, 0);
    foreach (dq[k]) begin
      bit ok;
      ok = s_ok && ptr < 9;
      wbyte(dq[k], ok, tag, glitch);
      if (ok) begin
        exp_reg[ptr] = dq[k];
        if (inc) ptr++;
      end
    end
    if (do_stop) bus_stop();
  endtask

  task automatic regs_check(input string tag);
    for (int i = 0; i < 9; i++)
      check(regs_o[i*8 +: 8] == exp_reg[i], tag, $sformatf("reg%0d", i),
            regs_o[i*8 +: 8], exp_reg[i]);
  endtask

  initial begin
    logic [7:0] rb;
    for (int i = 0; i < 9; i++) exp_reg[i] = 8'hFE;
    tick(10);
    rst = 1'b0;
    tick(2);
    regs_check("R6");
    check(!sda_oe, "R6", "sda_oe after reset", sda_oe, 0);
    quiet = 1'b1;

    // R1 and R4: single write, then repeated writes to one register
    dq.delete(); dq.push_back(8'hA5);
    txn(8'h88, 8'h02, 0, 1'b1, "R1");
    dq.delete(); dq.push_back(8'h11); dq.push_back(8'h22); dq.push_back(8'h33);
    txn(8'h88, 8'h01, 0, 1'b1, "R4");
    check(regs_o[15:8] == 8'h33, "R4", "last byte wins", regs_o[15:8], 8'h33);
    check(regs_o[23:16] == 8'hA5, "R4", "neighbour untouched", regs_o[23:16], 8'hA5);

    // R5: auto-increment runs and the end of the bank
    dq.delete();
    for (int i = 0; i < 5; i++) dq.push_back(8'h40 + 8'(i));
    txn(8'h88, 8'h14, 0, 1'b1, "R5");
    dq.delete();
    for (int i = 0; i < 4; i++) dq.push_back(8'h70 + 8'(i));
    txn(8'h88, 8'h17, 0, 1'b1, "R5");
    check(regs_o[71:64] == 8'h71, "R5", "reg8 holds last in-bank byte", regs_o[71:64], 8'h71);

    // R3: upper subaddress bits ignored; out-of-range index rejected
    dq.delete(); dq.push_back(8'h5A); dq.push_back(8'h5B);
    txn(8'h88, 8'hE0, 0, 1'b1, "R3");
    check(regs_o[7:0] == 8'h5B, "R3", "bits 7:5 ignored", regs_o[7:0], 8'h5B);
    dq.delete(); dq.push_back(8'h99);
    txn(8'h88, 8'h09, 0, 1'b1, "R3");
    txn(8'h88, 8'h1F, 0, 1'b1, "R3");
    regs_check("R3");

    // R2 and R1: address strap
    dq.delete(); dq.push_back(8'hC3);
    txn(8'h8A, 8'h03, 0, 1'b1, "R2");
    addr_sel = 1'b1;
    tick(4);
    txn(8'h8A, 8'h03, 0, 1'b1, "R1");
    check(regs_o[31:24] == 8'hC3, "R1", "strap high address", regs_o[31:24], 8'hC3);
    dq.delete(); dq.push_back(8'h3C);
    txn(8'h88, 8'h03, 0, 1'b1, "R2");
    addr_sel = 1'b0;
    tick(4);

    // R8: repeated START after a subaddress and after a mismatch
    dq.delete();
    txn(8'h88, 8'h05, 0, 1'b0, "R8");
    dq.push_back(8'h66);
    txn(8'h88, 8'h06, 0, 1'b1, "R8");
    check(regs_o[55:48] == 8'h66, "R8", "write after repeated start", regs_o[55:48], 8'h66);
    dq.delete(); dq.push_back(8'h12);
    txn(8'h90, 8'h00, 0, 1'b0, "R8");
    watch_rel = 1'b0;
    dq.delete(); dq.push_back(8'h01);
    txn(8'h88, 8'h00, 0, 1'b1, "R8");
    check(regs_o[7:0] == 8'h01, "R8", "decode restarted", regs_o[7:0], 8'h01);

    // R7: status reads, refreshed per byte, released after NACK
    soft_mute = 1'b1; zc_mute = 1'b0;
    bus_start();
    wbyte(8'h89, 1'b1, "R7", 0);
    rbyte(rb, 1'b1, 1'b0, 1'b1);
    check(rb == 8'hFD, "R7", "first status byte", rb, 8'hFD);
    rbyte(rb, 1'b1, 1'b1, 1'b1);
    check(rb == 8'hFB, "R7", "refreshed status byte", rb, 8'hFB);
    rbyte(rb, 1'b0, 1'b0, 1'b0);
    check(rb == 8'hFF, "R7", "both flags set", rb, 8'hFF);
    watch_rel = 1'b1;
    rbyte(rb, 1'b0, 1'b0, 1'b0);
    check(rb == 8'hFF, "R7", "released after NACK", rb, 8'hFF);
    bus_stop();
    regs_check("R7");

    // R10: short glitches on both lines are rejected
    dq.delete(); dq.push_back(8'h96);
    txn(8'h88, 8'h02, 1, 1'b1, "R10");
    check(regs_o[23:16] == 8'h96, "R10", "SCL glitch", regs_o[23:16], 8'h96);
    dq.delete(); dq.push_back(8'hE7);
    txn(8'h88, 8'h04, 2, 1'b1, "R10");
    check(regs_o[39:32] == 8'hE7, "R10", "SDA glitch", regs_o[39:32], 8'hE7);
    regs_check("R6");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule